// File: doc/BRIEF.md
# Serial Temperature Sensor Reader

This block is the master end of a read-only serial link to a temperature sensor that reports a 10-bit code. A one-cycle start request opens a transaction. The block then raises a chip-enable line and produces a serial clock by dividing the system clock. It shifts in a 16-bit frame, sampling the sensor's data line on each falling serial clock edge, because the sensor updates its output on rising edges.

The frame has a fixed layout. A leading zero comes first. Ten code bits follow, most significant first. The frame ends with five copies of the last code bit. The block checks the leading bit and the five trailing copies. It publishes the signed code together with an error flag and a one-cycle done pulse, and it does this only after chip enable has gone low again.

The divider ratio comes from the system clock rate and the highest permitted serial clock rate. This keeps the serial clock at or below 10 MHz. The block never writes to the sensor, so its output data line is held low at all times.

Top module: `tsense_reader`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `cs_o`, `sclk_o`, `busy_o`, `done_o`, `frame_err_o` and `mosi_o` are 0 and `temp_o` is 0.
- R2: An accepted start holds `cs_o` high for exactly 16 serial clock periods, which is 32*HALF_DIV system cycles. `sclk_o` stays low whenever `cs_o` is low.
- R3: Each level of `sclk_o` lasts at least HALF_DIV system cycles, where HALF_DIV = ceil(SYS_CLK_HZ / (2*SCLK_MAX_HZ)). The serial clock therefore never exceeds SCLK_MAX_HZ, which defaults to 10 MHz.
- R4: `sense_in` is sampled on the falling edges of `sclk_o`. Received bit 0 is the leading bit. Received bits 1 to 10 form `temp_o[9]` down to `temp_o[0]`. Received bits 11 to 15 are the trailing copies.
- R5: `temp_o` is two's complement with 0.25 degree C per LSB. Code 10'h200 reads as -512 and code 10'h1FF reads as +511.
- R6: `done_o` is a single-cycle pulse that is only ever high while `cs_o` is low. `temp_o` and `frame_err_o` change only in the `done_o` cycle and hold their values until the next one.
- R7: `frame_err_o` is 1 after a frame whose leading bit was 1.
- R8: `frame_err_o` is 1 after a frame in which any trailing bit differs from the last code bit. It is 0 after a frame with a zero leading bit and consistent trailing bits.
- R9: A start request that arrives while `busy_o` is high is ignored. The transaction in progress still produces exactly 16 serial clocks and one `done_o`, and no second transaction follows.
- R10: `mosi_o` is 0 in every cycle.
- R11: `busy_o` goes high in the cycle after an accepted start, is high whenever `cs_o` is high, and is low again in the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_req | input | 1 | One-cycle request to read the sensor |
| sense_in | input | 1 | Serial data from the sensor |
| sclk_o | output | 1 | Serial clock to the sensor, idles low |
| cs_o | output | 1 | Chip enable, active high |
| mosi_o | output | 1 | Data to the sensor, always low |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse when a result is published |
| temp_o | output | 10 | Signed temperature code, quarter degrees |
| frame_err_o | output | 1 | Last frame broke the framing rules |

## Verification
The bench builds the block with SYS_CLK_HZ = 40 MHz and SCLK_MAX_HZ = 10 MHz. With these values the divider rounds to exactly HALF_DIV = 2, so each serial level lasts exactly the minimum allowed time and each frame takes 64 system cycles. This lets the bench measure exact serial clock level lengths and the exact chip-enable window while keeping every frame short. The short frames leave room for sign-extreme codes, both kinds of framing corruption, and a start request in the middle of a frame.

// File: rtl/tsr_pkg.sv
// Shared types for the serial temperature sensor reader.
// Assumes nothing beyond a single clock domain.
package tsr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FINISH = 2'd2
    } tsr_state_e;
endpackage

// File: rtl/tsr_sclk_gen.sv
// Serial clock generator: while run is high, toggles sclk every HALF_DIV
// system cycles, starting low. It flags the cycle in which a falling edge is
// produced. Assumes run stays low between transactions so that each frame
// starts from a cleared divider.
module tsr_sclk_gen #(
    parameter int HALF_DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic fall_tick
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] div_cnt;
    logic          half_done;

    assign half_done = (div_cnt == CW'(HALF_DIV - 1));
    assign fall_tick = run && half_done && sclk;

    // Divider counter and serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
            sclk    <= 1'b0;
        end else if (half_done) begin
            div_cnt <= '0;
            sclk    <= ~sclk;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tsr_capture.sv
// Frame capture register: shifts the sensor bit in at the LSB whenever
// shift_en is high, so the first received bit ends up in the MSB.
// Assumes shift_en is asserted exactly once per falling serial edge.
module tsr_capture #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               shift_en,
    input  logic               din,
    output logic [FRAME_W-1:0] frame
);
    // Shift register for the received bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            frame <= '0;
        end else if (shift_en) begin
            frame <= {frame[FRAME_W-2:0], din};
        end
    end
endmodule

// File: rtl/tsr_frame_check.sv
// Frame decoder: extracts the temperature code and flags a framing error
// when the leading bit is set or a trailing copy differs from the last code
// bit. It is purely combinational and assumes the frame has been fully
// captured.
module tsr_frame_check #(
    parameter int CODE_W = 10,
    parameter int TAIL_W = 5
) (
    input  logic [CODE_W+TAIL_W:0] frame,
    output logic [CODE_W-1:0]      code,
    output logic                   bad
);
    localparam int FRAME_W = CODE_W + TAIL_W + 1;

    logic lead_bit;
    logic last_bit;
    logic tail_bad;

    // Field extraction and consistency test.
    always_comb begin
        lead_bit = frame[FRAME_W-1];
        code     = frame[FRAME_W-2 -: CODE_W];
        last_bit = frame[TAIL_W];
        tail_bad = (frame[TAIL_W-1:0] != {TAIL_W{last_bit}});
        bad      = lead_bit | tail_bad;
    end
endmodule

// File: rtl/tsense_reader.sv
// Top level of the serial temperature sensor reader. On start it raises
// chip enable, runs 16 serial clocks, captures the frame, and then, after
// chip enable has dropped, publishes the code, the error flag and a done
// pulse. Assumes SYS_CLK_HZ is the real system clock rate.
module tsense_reader #(
    parameter int SYS_CLK_HZ  = 100_000_000,
    parameter int SCLK_MAX_HZ = 10_000_000,
    parameter int CODE_W      = 10,
    parameter int TAIL_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              sense_in,
    output logic              sclk_o,
    output logic              cs_o,
    output logic              mosi_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [CODE_W-1:0] temp_o,
    output logic              frame_err_o
);
    import tsr_pkg::*;

    localparam int HALF_DIV = (SYS_CLK_HZ + 2*SCLK_MAX_HZ - 1) / (2*SCLK_MAX_HZ);
    localparam int FRAME_W  = CODE_W + TAIL_W + 1;
    localparam int BCW      = $clog2(FRAME_W);

    tsr_state_e          state;
    logic [BCW-1:0]      bit_cnt;
    logic                run;
    logic                fall_tick;
    logic                accept;
    logic [FRAME_W-1:0]  frame;
    logic [CODE_W-1:0]   code;
    logic                bad;

    assign run    = (state == ST_SHIFT);
    assign accept = (state == ST_IDLE) && start_req;
    assign cs_o   = run;
    assign busy_o = (state != ST_IDLE);
    assign mosi_o = 1'b0;

    tsr_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sclk      (sclk_o),
        .fall_tick (fall_tick)
    );

    tsr_capture #(.FRAME_W(FRAME_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .shift_en (fall_tick),
        .din      (sense_in),
        .frame    (frame)
    );

    tsr_frame_check #(.CODE_W(CODE_W), .TAIL_W(TAIL_W)) u_chkf (
        .frame (frame),
        .code  (code),
        .bad   (bad)
    );

    // Transaction sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            done_o      <= 1'b0;
            temp_o      <= '0;
            frame_err_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        state   <= ST_SHIFT;
                        bit_cnt <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (fall_tick) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == BCW'(FRAME_W - 1)) begin
                            state <= ST_FINISH;
                        end
                    end
                end
                ST_FINISH: begin
                    temp_o      <= code;
                    frame_err_o <= bad;
                    done_o      <= 1'b1;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tsr_checker.sv
// Property checker for tsense_reader, attached through bind. It observes
// the ports only and assumes the synchronous active-low reset.
module tsr_checker #(
    parameter int HALF_DIV = 5,
    parameter int CODE_W   = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk_o,
    input logic              cs_o,
    input logic              mosi_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [CODE_W-1:0] temp_o,
    input logic              frame_err_o
);
    logic prev_sclk;
    int   level_run;

    // Tracks how many cycles the serial clock has held its present level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sclk <= 1'b0;
            level_run <= HALF_DIV;
        end else begin
            prev_sclk <= sclk_o;
            if (sclk_o != prev_sclk) level_run <= 1;
            else if (level_run < HALF_DIV) level_run <= level_run + 1;
        end
    end

    AST_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n) !mosi_o); // R10
    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !cs_o |-> !sclk_o); // R2
    AST_SCLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (sclk_o != prev_sclk) |-> level_run >= HALF_DIV); // R3
    AST_DONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !cs_o); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done_o |=> (!done_o |-> ($stable(temp_o) && $stable(frame_err_o)))); // R6
    AST_CS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) cs_o |-> busy_o); // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !busy_o); // R11
endmodule

bind tsense_reader tsr_checker #(.HALF_DIV(HALF_DIV), .CODE_W(CODE_W)) u_prop (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_o      (sclk_o),
    .cs_o        (cs_o),
    .mosi_o      (mosi_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .temp_o      (temp_o),
    .frame_err_o (frame_err_o)
);

// File: tb/sim_tsense_reader.sv
// Directed bench for tsense_reader with a behavioural sensor model.
module sim_tsense_reader;
    localparam int CLK_PERIOD = 25;
    localparam int HALF       = 2;
    localparam int FW         = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0;
    logic       sense_in = 1'b0;
    logic       sclk_o, cs_o, mosi_o, busy_o, done_o, frame_err_o;
    logic [9:0] temp_o;

    logic [FW-1:0] tx_frame = '0;
    int idx = 0;
    int rise_cnt = 0, done_cnt = 0, cs_cycles = 0, min_level = 1000, lvl = 0;
    int mosi_bad = 0, sclk_idle_bad = 0;
    logic last_sclk = 1'b0;
    int n_chk = 0, n_fail = 0;

    tsense_reader #(.SYS_CLK_HZ(40_000_000), .SCLK_MAX_HZ(10_000_000)) u0 (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .sense_in(sense_in),
        .sclk_o(sclk_o), .cs_o(cs_o), .mosi_o(mosi_o), .busy_o(busy_o),
        .done_o(done_o), .temp_o(temp_o), .frame_err_o(frame_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Sensor model: presents the next bit on each rising serial edge.
    always @(posedge cs_o) idx = 0;
    always @(posedge sclk_o) begin
        if (cs_o) begin
            if (idx < FW) sense_in = tx_frame[FW-1-idx];
            idx++;
            rise_cnt++;
        end
    end

    // Port monitors.
    always @(posedge clk) begin
        if (rst_n) begin
            if (done_o) done_cnt++;
            if (cs_o) cs_cycles++;
            if (mosi_o) mosi_bad++;
            if (!cs_o && sclk_o) sclk_idle_bad++;
            if (sclk_o != last_sclk) begin
                if (cs_o && lvl < min_level) min_level = lvl;
                lvl = 1;
            end else lvl++;
            last_sclk = sclk_o;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [9:0] code, input logic lead,
                             input logic [4:0] tmask, input bit mid_start);
        tx_frame  = {lead, code, {5{code[0]}} ^ tmask};
        rise_cnt  = 0; done_cnt = 0; cs_cycles = 0; min_level = 1000;
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        chk("R11 busy after start", busy_o, 1);
        if (mid_start) begin
            repeat (20) @(negedge clk);
            start_req = 1'b1;
            @(negedge clk) start_req = 1'b0;
        end
        for (int w = 0; w < 2000 && !done_o; w++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 cs", cs_o, 0);
        chk("R1 sclk", sclk_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 temp", temp_o, 0);
        chk("R1 err", frame_err_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {cs_o, sclk_o, busy_o, done_o, frame_err_o, mosi_o}, 0);
    endtask

    task automatic t_good(input logic [9:0] code, input int exp_val);
        run_frame(code, 1'b0, 5'd0, 1'b0);
        chk("R6 done seen", done_o, 1);
        chk("R6 cs low at done", cs_o, 0);
        chk("R11 busy low at done", busy_o, 0);
        chk("R4 code bits", temp_o, code);
        chk("R5 signed value", int'($signed(temp_o)), exp_val);
        chk("R8 no error", frame_err_o, 0);
        chk("R2 serial clocks", rise_cnt, 16);
        chk("R2 cs window", cs_cycles, 32*HALF);
        chk("R3 min level", min_level, HALF);
        @(negedge clk);
        chk("R6 single pulse", done_o, 0);
        chk("R6 temp holds", temp_o, code);
    endtask

    task automatic t_lead_bad;
        run_frame(10'h155, 1'b1, 5'd0, 1'b0);
        chk("R7 leading one", frame_err_o, 1);
        chk("R4 code under bad lead", temp_o, 10'h155);
    endtask

    task automatic t_tail_bad(input logic [4:0] m);
        run_frame(10'h0A3, 1'b0, m, 1'b0);
        chk("R8 tail mismatch", frame_err_o, 1);
    endtask

    task automatic t_busy_start;
        run_frame(10'h07B, 1'b0, 5'd0, 1'b1);
        chk("R9 value", temp_o, 10'h07B);
        chk("R9 clocks", rise_cnt, 16);
        repeat (100) @(negedge clk);
        chk("R9 one done", done_cnt, 1);
        chk("R9 idle after", {busy_o, cs_o}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_good(10'h064, 100);
        t_good(10'h200, -512);
        t_good(10'h1FF, 511);
        t_lead_bad();
        t_good(10'h3FF, -1);
        t_tail_bad(5'b00001);
        t_tail_bad(5'b10000);
        t_good(10'h000, 0);
        t_busy_start();
        chk("R10 data line low", mosi_bad, 0);
        chk("R2 idle clock low", sclk_idle_bad, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule